// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block holds the control word of a frequency synthesizer: a feedback divide value, a post-divide select and a test-output select. The word can be written by either of two load paths. The serial path shifts bits in, one per rising edge of a serial clock, and commits the shifted word when its load strobe falls. The parallel path takes the feedback and post-divide values straight from input pins when its load strobe rises.

The two strobes, the serial clock and the serial data all arrive asynchronously. Each is passed through a two-stage synchronizer into the system clock domain, and edges are detected after the synchronizer. When both paths commit in the same cycle, the parallel path wins. The registered fields are driven out together with a one-hot decode of the post-divide ratio.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, m_o, n_o and t_o are zero and ratio_o is 4'b0001.
- R2: Each rising edge of ser_clk_i shifts ser_data_i into a 14-bit register, entering at the low end. A commit maps the register as bits [13:11] = T, [10:9] = N, [8:0] = M, so the first bit shifted in becomes T[2]. A commit with no new shifts loads the same word again.
- R3: A falling edge of ser_load_i loads T, N and M from the shift register when par_load_i is high. A rising edge of ser_load_i changes nothing.
- R4: While par_load_i is low, a falling edge of ser_load_i changes no output.
- R5: A rising edge of par_load_i loads M from par_m_i and N from par_n_i and leaves T unchanged. A falling edge of par_load_i changes nothing.
- R6: When a parallel rising edge and a serial falling edge are detected in the same cycle, M and N come from the pins and T keeps its old value.
- R7: ratio_o is one-hot with bit N set: N=0 gives 4'b0001 (divide by 1), 1 gives 4'b0010 (divide by 2), 2 gives 4'b0100 (divide by 4) and 3 gives 4'b1000 (divide by 8).
- R8: When more than 14 bits are shifted in, only the last 14 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial commit strobe, acts on its falling edge |
| par_load_i | input | 1 | Parallel capture strobe, acts on its rising edge |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel post-divide select |
| m_o | output | 9 | Registered feedback divide value |
| n_o | output | 2 | Registered post-divide select |
| t_o | output | 3 | Registered test-output select |
| ratio_o | output | 4 | One-hot post-divide ratio |

## Verification
The bench builds the block with its default widths: a 9-bit M, a 2-bit N, a 3-bit T and two synchronizer stages. These defaults make the whole 14-bit serial word reachable, together with all four ratio codes and an overrun of 16 shifted bits. The bench also drives a parallel rising edge and a serial falling edge so that they reach detection in the same system cycle, and a serial commit while the parallel strobe is low.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned CFG_M_W    = 9;
  localparam int unsigned CFG_N_W    = 2;
  localparam int unsigned CFG_T_W    = 3;
  localparam int unsigned CFG_STAGES = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SER  = 2'd1,
    SRC_PAR  = 2'd2
  } cfg_src_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  assign word_o = sr_q;

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
  a_r2_bit_enters_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[0] == $past(bit_i));
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import synth_cfg_pkg::*;
#(
  parameter int unsigned M_W = CFG_M_W,
  parameter int unsigned N_W = CFG_N_W,
  parameter int unsigned T_W = CFG_T_W,
  localparam int unsigned WORD_W  = T_W + N_W + M_W,
  localparam int unsigned RATIO_W = 1 << N_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_rise_i,
  input  logic               par_lvl_i,
  input  logic               ser_fall_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  output logic [M_W-1:0]     m_o,
  output logic [N_W-1:0]     n_o,
  output logic [T_W-1:0]     t_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic [T_W-1:0] t_q;
  cfg_src_e       src;

  // parallel edge outranks serial; serial gated by parallel strobe level
  always_comb begin
    if (par_rise_i)                   src = SRC_PAR;
    else if (ser_fall_i && par_lvl_i) src = SRC_SER;
    else                              src = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else begin
      unique case (src)
        SRC_PAR: begin
          m_q <= par_m_i;
          n_q <= par_n_i;
        end
        SRC_SER: {t_q, n_q, m_q} <= word_i;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < RATIO_W; k++) begin : g_ratio
    assign ratio_o[k] = (n_q == N_W'(k));
  end

  assign m_o = m_q;
  assign n_o = n_q;
  assign t_o = t_q;

  a_r5_m_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_rise_i |=> m_q == $past(par_m_i));
  a_r5_t_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_rise_i |=> $stable(t_q));
  a_r6_par_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_rise_i && ser_fall_i) |=> n_q == $past(par_n_i));
  a_r4_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_fall_i && !par_lvl_i) |=> $stable({t_q, n_q, m_q}));
  a_r3_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(par_rise_i || ser_fall_i) |=> $stable({t_q, n_q, m_q}));
  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ratio_o) == 1);
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int unsigned M_W         = CFG_M_W,
  parameter int unsigned N_W         = CFG_N_W,
  parameter int unsigned T_W         = CFG_T_W,
  parameter int unsigned SYNC_STAGES = CFG_STAGES,
  localparam int unsigned WORD_W  = T_W + N_W + M_W,
  localparam int unsigned RATIO_W = 1 << N_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_load_i,
  input  logic               par_load_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  output logic [M_W-1:0]     m_o,
  output logic [N_W-1:0]     n_o,
  output logic [T_W-1:0]     t_o,
  output logic [RATIO_W-1:0] ratio_o
);
  // bit order: {par_load, ser_load, ser_data, ser_clk}
  logic [3:0]        sync_q;
  logic [2:0]        dly_q;
  logic [2:0]        lvl;
  logic              sclk_rise, sload_fall, par_rise;
  logic [WORD_W-1:0] word;

  cfg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({par_load_i, ser_load_i, ser_data_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  assign lvl = {sync_q[3], sync_q[2], sync_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= lvl;
  end

  assign sclk_rise  = lvl[0] & ~dly_q[0];
  assign sload_fall = ~lvl[1] & dly_q[1];
  assign par_rise   = lvl[2] & ~dly_q[2];

  cfg_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .bit_i  (sync_q[1]),
    .word_o (word)
  );

  cfg_commit #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_rise_i(par_rise),
    .par_lvl_i (lvl[2]),
    .ser_fall_i(sload_fall),
    .word_i    (word),
    .par_m_i   (par_m_i),
    .par_n_i   (par_n_i),
    .m_o       (m_o),
    .n_o       (n_o),
    .t_o       (t_o),
    .ratio_o   (ratio_o)
  );

  a_r3_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sload_fall |=> !sload_fall);
  a_r5_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_rise |=> !par_rise);
endmodule

// File: tb/synth_cfg_loader_test.sv
`timescale 1ns/1ps
module synth_cfg_loader_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_load_i = 1'b0, par_load_i = 1'b0;
  logic [8:0] par_m_i = 9'h1FF;
  logic [1:0] par_n_i = 2'b11;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic [3:0] ratio_o;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic [3:0] r;
    int         due;
    string      tag;
  } exp_t;
  exp_t q[$];

  synth_cfg_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i),
    .ser_load_i(ser_load_i), .par_load_i(par_load_i), .par_m_i(par_m_i),
    .par_n_i(par_n_i), .m_o(m_o), .n_o(n_o), .t_o(t_o), .ratio_o(ratio_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cfg(input logic [8:0] m, input logic [1:0] n,
                            input logic [2:0] t, input string tag);
    exp_t e;
    e.m = m; e.n = n; e.t = t; e.r = 4'(1 << n); e.due = cyc + 6; e.tag = tag;
    q.push_back(e);
    ticks(8);
  endtask

  task automatic send(input logic [15:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_data_i = v[i];
      ticks(3);
      ser_clk_i = 1'b1;
      ticks(3);
      ser_clk_i = 1'b0;
      ticks(3);
    end
  endtask

  task automatic pulse_sload();
    ser_load_i = 1'b1;
    ticks(4);
    ser_load_i = 1'b0;
  endtask

  task automatic par_cycle(input logic [8:0] m, input logic [1:0] n);
    par_load_i = 1'b0;
    ticks(5);
    par_m_i = m;
    par_n_i = n;
    ticks(2);
    par_load_i = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0 && cyc >= q[0].due) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (m_o !== e.m || n_o !== e.n || t_o !== e.t || ratio_o !== e.r) begin
        fails++;
        $display("FAIL %s: actual m=%h n=%0d t=%0d ratio=%b expected m=%h n=%0d t=%0d ratio=%b",
                 e.tag, m_o, n_o, t_o, ratio_o, e.m, e.n, e.t, e.r);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rst_ni = 1'b1;
    ticks(2);
    expect_cfg(9'h000, 2'd0, 3'd0, "R1 reset");

    // R5 parallel capture
    par_cycle(9'h0A5, 2'd2);
    expect_cfg(9'h0A5, 2'd2, 3'd0, "R5 parallel rise");

    // R2/R3 serial word {T=5,N=1,M=13C}
    send({2'b00, 3'b101, 2'b01, 9'h13C}, 14);
    ser_load_i = 1'b1;
    expect_cfg(9'h0A5, 2'd2, 3'd0, "R3 serial rise no effect");
    ser_load_i = 1'b0;
    expect_cfg(9'h13C, 2'd1, 3'd5, "R3 R2 serial commit");

    // R5 falling parallel strobe changes nothing
    par_load_i = 1'b0;
    expect_cfg(9'h13C, 2'd1, 3'd5, "R5 parallel fall no effect");

    // R4 serial commit blocked while parallel strobe low
    send({2'b00, 3'b011, 2'b11, 9'h0F0}, 14);
    pulse_sload();
    expect_cfg(9'h13C, 2'd1, 3'd5, "R4 gated commit");

    // R5 T kept on parallel load
    par_cycle(9'h055, 2'd0);
    expect_cfg(9'h055, 2'd0, 3'd5, "R5 T unchanged");

    // R2 recommit of retained shift word
    pulse_sload();
    expect_cfg(9'h0F0, 2'd3, 3'd3, "R2 recommit");

    // R7 all ratio codes
    for (int k = 0; k < 4; k++) begin
      par_cycle(9'(9'h100 + k), 2'(k));
      expect_cfg(9'(9'h100 + k), 2'(k), 3'd3, "R7 ratio decode");
    end

    // R8 overrun: two extra leading bits dropped
    send({2'b11, 3'b110, 2'b10, 9'h0AB}, 16);
    pulse_sload();
    expect_cfg(9'h0AB, 2'd2, 3'd6, "R8 last 14 bits");

    // R6 simultaneous commit
    par_load_i = 1'b0;
    ticks(5);
    send({2'b00, 3'b001, 2'b01, 9'h1C3}, 14);
    par_m_i = 9'h02E;
    par_n_i = 2'd1;
    ser_load_i = 1'b1;
    ticks(5);
    par_load_i = 1'b1;
    ser_load_i = 1'b0;
    expect_cfg(9'h02E, 2'd1, 3'd6, "R6 parallel priority");

    ticks(4);
    while (q.size() > 0) ticks(1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule